// File: doc/BRIEF.md
# MLT-3 Transmit Serializer

This block turns a stream of 5-bit code groups into a three-level serial symbol stream for a 100 Mb/s copper line driver. It runs entirely on the 125 MHz bit clock. It divides that clock by five to produce a 25 MHz transmit clock. An upstream coding layer uses that clock to present one code group per period. On the bit-clock edge where the transmit clock rises, the input word is caught in a holding register. On the next edge the word moves into a parallel-in/serial-out shifter. The shifter then sends one bit per bit-clock cycle, least significant bit first, with no gap between words.

The serial bit feeds an NRZI stage, where a 1 flips the line state and a 0 leaves it alone. Every NRZI transition then advances a four-step MLT-3 walk through zero, positive, zero and negative. The result leaves as a 2-bit signed level code together with a drive-enable flag for the analog driver. The drive flag and the level code are forced inactive when the output enable is low or loopback is selected. The encoder state keeps running underneath that gating.

Top module: `mlt3_tx_serializer`

## Requirements
- R1: `txClk` is the bit clock divided by five: high for two bit-clock cycles and low for three. Counting the first bit-clock edge after reset release as edge 1, it rises on edges 5, 10, 15 and so on.
- R2: `txData` is sampled on the bit-clock edge at which `txClk` rises; its value at other edges has no effect.
- R3: A captured word enters the shifter one edge after capture and is sent bit 0 first, one bit per bit-clock cycle. Five bits are sent per word, and consecutive words follow back to back.
- R4: The serial path is NRZI coded: a 1 bit toggles the NRZI state and a 0 bit holds it.
- R5: The level walks 0, +1, 0, -1 and repeats, advancing one step per NRZI transition. The codes are `2'b00` for 0, `2'b01` for +1 and `2'b11` for -1, and `2'b10` never appears. Bit i of a word captured at edge E takes effect on `lineLevel` at edge E+3+i.
- R6: While `txOutEn` is low, `lineDrive` is low and `lineLevel` is `2'b00`, in the same cycle.
- R7: While `loopbackEn` is high, `lineDrive` is low and `lineLevel` is `2'b00`, in the same cycle.
- R8: After reset `txClk` is high, `lineLevel` is 0 and the NRZI state is 0. The next nonzero level is +1. Until the first captured word reaches the shifter, only zeros are sent.
- R9: Gating by `txOutEn` or `loopbackEn` does not disturb the encoder. When drive returns, the level is the one the ungated stream would have at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txData | input | 5 | Code group from the upstream layer, sampled when `txClk` rises |
| txOutEn | input | 1 | Line output enable; low forces the driver off |
| loopbackEn | input | 1 | Loopback select; high forces the driver off |
| txClk | output | 1 | 25 MHz transmit clock for the upstream layer |
| lineLevel | output | 2 | Signed level code: 00 zero, 01 positive, 11 negative |
| lineDrive | output | 1 | Driver enable; low means the line is tri-stated |

## Verification
`txClk` is registered, so after bit-clock edge n it equals whether n mod 5 is 0 or 1. The bench predicts it from the edge count alone. A word applied before edge E, with E a multiple of five, must show bit i on `lineLevel` from edge E+3+i: one edge for the holding register, one for the shifter load, one for the NRZI register and one for the level register. The bench therefore schedules each bit at that edge in a ring of expected transitions. It compares the outputs at the falling edge that follows every rising edge. The gating is combinational, so the drive and level checks use the enable values the bench applied at the previous falling edge.

// File: rtl/mlt3_tx_pkg.sv
package mlt3_tx_pkg;

  // Strobes from the control to the datapath, one set per bit-clock cycle.
  typedef struct packed {
    logic capture;  // last cycle of a word period: holding register takes txData
    logic load;     // first cycle of a word period: shifter takes holding register
    logic shift;    // all other cycles: shifter advances one bit
    logic driveEn;  // line driver may be active
  } txStrobes_t;

  // Position in the four-step walk of the three-level code.
  typedef enum logic [1:0] {
    STEP_ZERO_RISE = 2'd0,
    STEP_POS       = 2'd1,
    STEP_ZERO_FALL = 2'd2,
    STEP_NEG       = 2'd3
  } mltStep_t;

  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_NEG  = 2'b11;

  function automatic mltStep_t nextStep(input mltStep_t cur);
    case (cur)
      STEP_ZERO_RISE: nextStep = STEP_POS;
      STEP_POS:       nextStep = STEP_ZERO_FALL;
      STEP_ZERO_FALL: nextStep = STEP_NEG;
      default:        nextStep = STEP_ZERO_RISE;
    endcase
  endfunction

  function automatic logic [1:0] levelCode(input mltStep_t cur);
    case (cur)
      STEP_POS: levelCode = LVL_POS;
      STEP_NEG: levelCode = LVL_NEG;
      default:  levelCode = LVL_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/mlt3_tx_ctrl.sv
module mlt3_tx_ctrl
  import mlt3_tx_pkg::*;
#(
  parameter int WORD_W   = 5,
  parameter int CLK_HIGH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txOutEn,
  input  logic       loopbackEn,
  output txStrobes_t strobes,
  output logic       txClk
);

  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HIGH_LIMIT = CNT_W'(CLK_HIGH);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseNext;

  always_comb begin
    if (phaseCnt == LAST_PHASE) phaseNext = '0;
    else                        phaseNext = phaseCnt + CNT_W'(1);
  end

  // Registered divided clock: high while the phase is below HIGH_LIMIT.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      txClk    <= (CLK_HIGH > 0);
    end else begin
      phaseCnt <= phaseNext;
      txClk    <= (phaseNext < HIGH_LIMIT);
    end
  end

  always_comb begin
    strobes.capture = (phaseCnt == LAST_PHASE);
    strobes.load    = (phaseCnt == '0);
    strobes.shift   = (phaseCnt != '0);
    strobes.driveEn = txOutEn & ~loopbackEn;
  end

endmodule

// File: rtl/mlt3_tx_datapath.sv
module mlt3_tx_datapath
  import mlt3_tx_pkg::*;
#(
  parameter int WORD_W    = 5,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [WORD_W-1:0] txData,
  output logic [1:0]        lineLevel
);

  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;
  logic              serialBit;
  logic              nrziLvl;
  logic              nrziPrev;
  logic              nrziEdge;
  mltStep_t          mltStep;

  // Bit order of the serializer is picked by parameter.
  generate
    if (LSB_FIRST) begin : g_lsbFirst
      assign serialBit = shiftReg[0];
      assign shiftNext = {1'b0, shiftReg[WORD_W-1:1]};
    end else begin : g_msbFirst
      assign serialBit = shiftReg[WORD_W-1];
      assign shiftNext = {shiftReg[WORD_W-2:0], 1'b0};
    end
  endgenerate

  // Stage 1 and 2: holding register, then parallel-in/serial-out shifter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (strobes.capture) holdReg <= txData;
      if (strobes.load)       shiftReg <= holdReg;
      else if (strobes.shift) shiftReg <= shiftNext;
    end
  end

  // Stage 3: NRZ to NRZI, a one flips the state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nrziLvl  <= 1'b0;
      nrziPrev <= 1'b0;
    end else begin
      nrziLvl  <= nrziLvl ^ serialBit;
      nrziPrev <= nrziLvl;
    end
  end

  assign nrziEdge = nrziLvl ^ nrziPrev;

  // Stage 4: NRZI to three-level walk, one step per NRZI transition.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         mltStep <= STEP_ZERO_RISE;
    else if (nrziEdge) mltStep <= nextStep(mltStep);
  end

  assign lineLevel = strobes.driveEn ? levelCode(mltStep) : LVL_ZERO;

endmodule

// File: rtl/mlt3_tx_serializer.sv
module mlt3_tx_serializer
  import mlt3_tx_pkg::*;
#(
  parameter int WORD_W    = 5,
  parameter int CLK_HIGH  = 2,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] txData,
  input  logic              txOutEn,
  input  logic              loopbackEn,
  output logic              txClk,
  output logic [1:0]        lineLevel,
  output logic              lineDrive
);

  txStrobes_t strobes;

  mlt3_tx_ctrl #(
    .WORD_W   (WORD_W),
    .CLK_HIGH (CLK_HIGH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txOutEn    (txOutEn),
    .loopbackEn (loopbackEn),
    .strobes    (strobes),
    .txClk      (txClk)
  );

  mlt3_tx_datapath #(
    .WORD_W    (WORD_W),
    .LSB_FIRST (LSB_FIRST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .txData    (txData),
    .lineLevel (lineLevel)
  );

  assign lineDrive = strobes.driveEn;

endmodule

// File: rtl/mlt3_tx_checker.sv
module mlt3_tx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       txClk,
  input logic       txOutEn,
  input logic       loopbackEn,
  input logic       lineDrive,
  input logic [1:0] lineLevel,
  input logic       captureStb,
  input logic       loadStb
);

  AST_TXCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txClk) |=> txClk ##1 !txClk);                                   // R1

  AST_TXCLK_LOW_THREE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txClk) |=> !txClk ##1 !txClk ##1 txClk);                        // R1

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |=> $rose(txClk));                                         // R2

  AST_LOAD_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |=> loadStb);                                              // R3

  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    lineLevel != 2'b10);                                                  // R5

  AST_LEVEL_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (lineDrive && $past(lineDrive) && (lineLevel != $past(lineLevel)))
      |-> (lineLevel == 2'b00 || $past(lineLevel) == 2'b00));             // R5

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !txOutEn |-> (!lineDrive && lineLevel == 2'b00));                     // R6

  AST_LOOP_GATE: assert property (@(posedge clk) disable iff (!rstN)
    loopbackEn |-> (!lineDrive && lineLevel == 2'b00));                   // R7

endmodule

bind mlt3_tx_serializer mlt3_tx_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .txClk      (txClk),
  .txOutEn    (txOutEn),
  .loopbackEn (loopbackEn),
  .lineDrive  (lineDrive),
  .lineLevel  (lineLevel),
  .captureStb (strobes.capture),
  .loadStb    (strobes.load)
);

// File: tb/mlt3_tx_serializer_bench.sv
module mlt3_tx_serializer_bench;

  localparam int NUM_EDGES = 2500;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] txData = 5'd0;
  logic       txOutEn = 1'b1;
  logic       loopbackEn = 1'b0;
  logic       txClk;
  logic [1:0] lineLevel;
  logic       lineDrive;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  mlt3_tx_serializer u_mlt3_tx_serializer (
    .clk        (clk),
    .rstN       (rstN),
    .txData     (txData),
    .txOutEn    (txOutEn),
    .loopbackEn (loopbackEn),
    .txClk      (txClk),
    .lineLevel  (lineLevel),
    .lineDrive  (lineDrive)
  );

  always #2 clk = ~clk;

  // Expected level code for a count of NRZI transitions (R5 walk and encoding).
  function automatic logic [1:0] expLevel(input int steps);
    case (steps % 4)
      1:       expLevel = 2'b01;
      3:       expLevel = 2'b11;
      default: expLevel = 2'b00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  initial begin
    int   steps;
    bit   sched [16];
    bit   wasGated;
    logic [4:0] curWord;
    int   wordIdx;
    void'($urandom(32'd20240607));
    steps = 0;
    wasGated = 1'b0;
    wordIdx = 0;
    foreach (sched[k]) sched[k] = 1'b0;

    // Reset state, R8.
    repeat (3) @(negedge clk);
    check("R8 txClk in reset", {1'b0, txClk}, 2'b01);
    check("R8 level in reset", lineLevel, 2'b00);
    check("R8 drive in reset", {1'b0, lineDrive}, 2'b01);

    curWord = 5'b11111;
    txData  = curWord;
    rstN    = 1'b1;

    for (int n = 1; n <= NUM_EDGES; n++) begin
      logic expDrive;
      @(negedge clk);
      // R1: divided clock, high after edges where n mod 5 is 0 or 1.
      check("R1 txClk", {1'b0, txClk}, {1'b0, ((n % 5) < 2)});

      // R2 / R3: word captured at edge n reaches the line bit 0 first from edge n+3.
      if (n % 5 == 0) begin
        for (int i = 0; i < 5; i++) sched[(n + 3 + i) % 16] = curWord[i];
      end
      // R4 / R5: every one bit is one NRZI transition and one level step.
      if (sched[n % 16]) steps++;
      sched[n % 16] = 1'b0;

      expDrive = txOutEn & ~loopbackEn;
      if (!txOutEn) begin
        check("R6 drive with output disabled", {1'b0, lineDrive}, 2'b00);
        check("R6 level with output disabled", lineLevel, 2'b00);
      end else if (loopbackEn) begin
        check("R7 drive in loopback", {1'b0, lineDrive}, 2'b00);
        check("R7 level in loopback", lineLevel, 2'b00);
      end else if (wasGated) begin
        check("R9 level after gating ends", lineLevel, expLevel(steps));
        check("R9 drive after gating ends", {1'b0, lineDrive}, 2'b01);
      end else begin
        check("R2 R3 R4 R5 serial level", lineLevel, expLevel(steps));
        check("R6 R7 drive on", {1'b0, lineDrive}, 2'b01);
      end
      wasGated = !expDrive;

      // New word after each capture edge: directed patterns, then random.
      if (n % 5 == 0) begin
        wordIdx++;
        if (wordIdx < 4)       curWord = 5'b11111;
        else if (wordIdx < 7)  curWord = 5'b00000;
        else if (wordIdx == 7) curWord = 5'b00001;   // R3 bit 0 first
        else if (wordIdx == 8) curWord = 5'b10000;   // R3 bit 4 last
        else                   curWord = 5'($urandom);
        txData = curWord;
      end else if (wordIdx > 10 && ($urandom % 4 == 0)) begin
        // R2: changes away from the capture edge must be ignored; restored before it.
        txData = 5'($urandom);
      end
      if (n % 5 == 4) txData = curWord;

      if (wordIdx > 20) begin
        txOutEn    = ($urandom % 6 != 0);
        loopbackEn = ($urandom % 9 == 0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule